// File: doc/BRIEF.md
# Exception Entry State Updater

This block produces the architectural state that a processor core installs when it enters an exception handler. On the clock edge where the take-trap strobe is high, it samples the current 64-bit machine-state register, the address of the faulting instruction, a five-bit cause vector and a handler vector offset. One cycle later it presents four results: the handler's machine state, the saved return address, the saved machine state with cause bits merged in, and the handler fetch address. Each result has its own valid flag.

The handler machine state starts from the old one. A fixed set of control bits is cleared. The 64-bit mode and little-endian bits are forced on. A suspended transaction is downgraded. The saved machine state starts from the old one as well, with a reserved field cleared and the cause bits overwritten from the cause vector. The block does not decide whether a trap is taken, and it does not handle the return path.

Top module: `exc_entry_update`

## Requirements
- R1: While reset is active, and in the first cycle after it, all four data outputs and all four valid flags are zero.
- R2: When a trap is taken, the handler MSR has these bits cleared: 1, 2, 4, 5, 7, 8, 9, 10, 11, 13, 14, 15, 23, 25 and 32 (LSB-0 numbering).
- R3: When a trap is taken, the handler MSR has bit 63 (64-bit mode) and bit 0 (little-endian) set. Every bit not named in R2, R3 or R4 keeps its old value.
- R4: The transaction-state field of the handler MSR is bits [34:33]. If the old value of that field is 2'b10, the new value is 2'b01. Otherwise the old value is kept.
- R5: The saved return address equals the current instruction address.
- R6: The saved MSR copies the old MSR, with bits [30:27] cleared and bit 21 cleared.
- R7: In the saved MSR, bit 20 takes cause bit 0, bit 18 takes cause bit 1, bit 16 takes cause bit 3 and bit 19 takes cause bit 4. Cause bit 2 has no effect on any output.
- R8: Saved-MSR bit 17 is 1 exactly when the whole cause vector is zero.
- R9: The handler fetch address equals the vector offset, zero-extended to 64 bits and shifted left by 4.
- R10: The four valid flags are always equal. In the cycle after a sampled strobe they are 1. In the cycle after an edge with the strobe low, they are 0 and all data outputs are 0.
- R11: Results appear exactly one clock after the edge where the inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Take-trap strobe |
| cur_msr_i | input | 64 | Current machine-state register |
| cur_pc_i | input | 64 | Address of the trapping instruction |
| cause_vec_i | input | 5 | Trap cause vector |
| vec_off_i | input | OFF_W (12) | Handler vector offset |
| new_msr_o | output | 64 | Handler machine state |
| new_msr_vld_o | output | 1 | new_msr_o valid |
| save_pc_o | output | 64 | Saved return address |
| save_pc_vld_o | output | 1 | save_pc_o valid |
| save_msr_o | output | 64 | Saved machine state with cause bits |
| save_msr_vld_o | output | 1 | save_msr_o valid |
| fetch_pc_o | output | 64 | Handler fetch address |
| fetch_pc_vld_o | output | 1 | fetch_pc_o valid |

## Verification
The bench drives an all-ones MSR and checks it against a hand-computed value. A swapped or missing clear bit would leave a stray one in the handler MSR. It walks the transaction-state field through all four values; a design that rewrote every state, or wrote 2'b01 to the wrong bit, would miss 2'b10 or disturb 2'b11. It drives only cause bit 2, which must produce no cause and no trap bit, and a zero cause, which must produce only the trap bit. Misrouted cause wiring shows up as a wrong bit position in the saved MSR. Back-to-back strobes followed by an idle cycle catch valid flags that stick high or stale data that leaks through.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN    = 64;
    localparam int CAUSE_W = 5;

    // handler MSR bit policy (LSB-0 positions)
    localparam int POS_MODE64 = 63;
    localparam int POS_LITEND = 0;
    localparam int POS_TS_LO  = 33;
    localparam int TS_W       = 2;

    localparam int N_CLR = 15;
    localparam int CLR_POS [N_CLR] = '{5, 4, 11, 8, 15, 1, 32, 25, 23, 14, 13, 2, 10, 9, 7};

    // saved MSR field positions
    localparam int RSV_LO       = 27;
    localparam int RSV_HI       = 30;
    localparam int POS_TMBAD    = 21;
    localparam int POS_CAUSE_TRAP = 17;
    // destination bit for each cause vector bit; -1 means unused
    localparam int CAUSE_DST [CAUSE_W] = '{20, 18, -1, 16, 19};

    localparam logic [TS_W-1:0] TS_SUSPENDED = 2'b10;
    localparam logic [TS_W-1:0] TS_DOWNGRADE = 2'b01;

    function automatic logic [XLEN-1:0] clr_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < N_CLR; i++) m[CLR_POS[i]] = 1'b1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] set_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[POS_MODE64] = 1'b1;
        m[POS_LITEND] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] MSR_CLR = clr_mask();
    localparam logic [XLEN-1:0] MSR_SET = set_mask();

    typedef enum logic [1:0] {
        BIT_KEEP  = 2'd0,
        BIT_CLEAR = 2'd1,
        BIT_FORCE = 2'd2
    } bit_pol_e;

    typedef struct packed {
        logic [XLEN-1:0] new_msr;
        logic [XLEN-1:0] save_pc;
        logic [XLEN-1:0] save_msr;
        logic [XLEN-1:0] fetch_pc;
        logic [3:0]      vld;
    } exc_state_t;

endpackage

// File: rtl/exc_msr_xform.sv
module exc_msr_xform
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] old_msr_i,
    output logic [XLEN-1:0] new_msr_o
);

    logic [XLEN-1:0] masked;
    logic [TS_W-1:0] ts_old;
    logic [TS_W-1:0] ts_new;

    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        localparam bit_pol_e POL = MSR_SET[b] ? BIT_FORCE :
                                   MSR_CLR[b] ? BIT_CLEAR : BIT_KEEP;
        if (POL == BIT_FORCE) begin : g_force
            assign masked[b] = 1'b1;
        end else if (POL == BIT_CLEAR) begin : g_clear
            assign masked[b] = 1'b0;
        end else begin : g_keep
            assign masked[b] = old_msr_i[b];
        end
    end

    assign ts_old = old_msr_i[POS_TS_LO +: TS_W];

    always_comb begin
        ts_new = ts_old;
        if (ts_old == TS_SUSPENDED) ts_new = TS_DOWNGRADE;
    end

    always_comb begin
        new_msr_o = masked;
        new_msr_o[POS_TS_LO +: TS_W] = ts_new;
    end

endmodule

// File: rtl/exc_cause_encode.sv
module exc_cause_encode
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0]    old_msr_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    save_msr_o
);

    always_comb begin
        save_msr_o = old_msr_i;
        save_msr_o[RSV_HI:RSV_LO] = '0;
        save_msr_o[POS_TMBAD] = 1'b0;
        save_msr_o[POS_CAUSE_TRAP] = (cause_i == '0);
        for (int i = 0; i < CAUSE_W; i++) begin
            if (CAUSE_DST[i] >= 0) save_msr_o[CAUSE_DST[i]] = cause_i[i];
        end
    end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
#(
    parameter int OFF_W     = 12,
    parameter int VEC_SHIFT = 4
) (
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  pc_o
);

    localparam int USED_W = OFF_W + VEC_SHIFT;

    if (USED_W >= XLEN) begin : g_trunc
        assign pc_o = XLEN'({off_i, {VEC_SHIFT{1'b0}}});
    end else begin : g_ext
        assign pc_o = {{(XLEN - USED_W){1'b0}}, off_i, {VEC_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/exc_entry_update.sv
module exc_entry_update
    import exc_entry_pkg::*;
#(
    parameter int OFF_W     = 12,
    parameter int VEC_SHIFT = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trap_i,
    input  logic [63:0]        cur_msr_i,
    input  logic [63:0]        cur_pc_i,
    input  logic [4:0]         cause_vec_i,
    input  logic [OFF_W-1:0]   vec_off_i,
    output logic [63:0]        new_msr_o,
    output logic               new_msr_vld_o,
    output logic [63:0]        save_pc_o,
    output logic               save_pc_vld_o,
    output logic [63:0]        save_msr_o,
    output logic               save_msr_vld_o,
    output logic [63:0]        fetch_pc_o,
    output logic               fetch_pc_vld_o
);

    exc_state_t st_d, st_q;

    logic [XLEN-1:0] msr_nx;
    logic [XLEN-1:0] smsr_nx;
    logic [XLEN-1:0] fpc_nx;

    exc_msr_xform u_msr (
        .old_msr_i (cur_msr_i),
        .new_msr_o (msr_nx)
    );

    exc_cause_encode u_cause (
        .old_msr_i  (cur_msr_i),
        .cause_i    (cause_vec_i),
        .save_msr_o (smsr_nx)
    );

    exc_vector_calc #(
        .OFF_W     (OFF_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_vec (
        .off_i (vec_off_i),
        .pc_o  (fpc_nx)
    );

    always_comb begin
        st_d = '0;
        if (trap_i) begin
            st_d.new_msr  = msr_nx;
            st_d.save_pc  = cur_pc_i;
            st_d.save_msr = smsr_nx;
            st_d.fetch_pc = fpc_nx;
            st_d.vld      = '1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign new_msr_o      = st_q.new_msr;
    assign save_pc_o      = st_q.save_pc;
    assign save_msr_o     = st_q.save_msr;
    assign fetch_pc_o     = st_q.fetch_pc;
    assign new_msr_vld_o  = st_q.vld[0];
    assign save_pc_vld_o  = st_q.vld[1];
    assign save_msr_vld_o = st_q.vld[2];
    assign fetch_pc_vld_o = st_q.vld[3];

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int OFF_W     = 12,
    parameter int VEC_SHIFT = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             trap_i,
    input logic [63:0]      cur_msr_i,
    input logic [63:0]      cur_pc_i,
    input logic [4:0]       cause_vec_i,
    input logic [OFF_W-1:0] vec_off_i,
    input logic [63:0]      new_msr_o,
    input logic             new_msr_vld_o,
    input logic [63:0]      save_pc_o,
    input logic             save_pc_vld_o,
    input logic [63:0]      save_msr_o,
    input logic             save_msr_vld_o,
    input logic [63:0]      fetch_pc_o,
    input logic             fetch_pc_vld_o
);

    logic live_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    // R10
    vld_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (new_msr_vld_o == save_pc_vld_o) && (save_pc_vld_o == save_msr_vld_o)
        && (save_msr_vld_o == fetch_pc_vld_o));

    // R11
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q |-> (new_msr_vld_o == $past(trap_i)));

    // R10
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !new_msr_vld_o |-> (new_msr_o == '0 && save_pc_o == '0
                            && save_msr_o == '0 && fetch_pc_o == '0));

    // R2
    msr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_msr_vld_o |-> ((new_msr_o & MSR_CLR) == '0));

    // R3
    msr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_msr_vld_o |-> (new_msr_o[63] && new_msr_o[0]));

    // R4
    ts_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(trap_i) && $past(cur_msr_i[34:33]) == 2'b10)
        |-> (new_msr_o[34:33] == 2'b01));

    // R5
    save_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(trap_i)) |-> (save_pc_o == $past(cur_pc_i)));

    // R6
    save_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        save_msr_vld_o |-> (save_msr_o[30:27] == 4'd0 && !save_msr_o[21]));

    // R8
    trap_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(trap_i)) |-> (save_msr_o[17] == ($past(cause_vec_i) == 5'd0)));

    // R9
    fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(trap_i)) |-> (fetch_pc_o == (64'($past(vec_off_i)) << VEC_SHIFT)));

endmodule

bind exc_entry_update exc_entry_chk #(
    .OFF_W     (OFF_W),
    .VEC_SHIFT (VEC_SHIFT)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .trap_i         (trap_i),
    .cur_msr_i      (cur_msr_i),
    .cur_pc_i       (cur_pc_i),
    .cause_vec_i    (cause_vec_i),
    .vec_off_i      (vec_off_i),
    .new_msr_o      (new_msr_o),
    .new_msr_vld_o  (new_msr_vld_o),
    .save_pc_o      (save_pc_o),
    .save_pc_vld_o  (save_pc_vld_o),
    .save_msr_o     (save_msr_o),
    .save_msr_vld_o (save_msr_vld_o),
    .fetch_pc_o     (fetch_pc_o),
    .fetch_pc_vld_o (fetch_pc_vld_o)
);

// File: tb/sim_exc_entry_update.sv
`timescale 1ns/1ps
module sim_exc_entry_update;

    localparam int OFF_W = 12;
    localparam int NV    = 8;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             trap_i = 1'b0;
    logic [63:0]      cur_msr_i = '0;
    logic [63:0]      cur_pc_i = '0;
    logic [4:0]       cause_vec_i = '0;
    logic [OFF_W-1:0] vec_off_i = '0;
    logic [63:0]      new_msr_o, save_pc_o, save_msr_o, fetch_pc_o;
    logic             new_msr_vld_o, save_pc_vld_o, save_msr_vld_o, fetch_pc_vld_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    exc_entry_update #(.OFF_W(OFF_W), .VEC_SHIFT(4)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .trap_i(trap_i),
        .cur_msr_i(cur_msr_i), .cur_pc_i(cur_pc_i),
        .cause_vec_i(cause_vec_i), .vec_off_i(vec_off_i),
        .new_msr_o(new_msr_o), .new_msr_vld_o(new_msr_vld_o),
        .save_pc_o(save_pc_o), .save_pc_vld_o(save_pc_vld_o),
        .save_msr_o(save_msr_o), .save_msr_vld_o(save_msr_vld_o),
        .fetch_pc_o(fetch_pc_o), .fetch_pc_vld_o(fetch_pc_vld_o)
    );

    // stimulus: {msr, pc, cause, offset}
    localparam logic [64+64+5+12-1:0] VEC [NV] = '{
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_1000, 5'b00000, 12'h070},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFC, 5'b00001, 12'hFFF},
        {64'h0000_0004_0000_0000, 64'h0000_0000_DEAD_BEE0, 5'b00010, 12'h001},
        {64'h0000_0006_0000_0000, 64'h1234_5678_9ABC_DEF0, 5'b01000, 12'h0A5},
        {64'h0000_0002_7800_0000, 64'h0000_0000_0000_0004, 5'b10000, 12'h800},
        {64'hA5A5_A5A5_5A5A_5A5A, 64'h0F0F_0F0F_0F0F_0F0C, 5'b11011, 12'h123},
        {64'h5A5A_5A5A_A5A5_A5A5, 64'h8000_0000_0000_0000, 5'b00100, 12'h3C0},
        {64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0700, 5'b10101, 12'h7FF}
    };

    function automatic logic [63:0] ref_msr(input logic [63:0] m);
        logic [63:0] r;
        int clr [15] = '{1, 2, 4, 5, 7, 8, 9, 10, 11, 13, 14, 15, 23, 25, 32};
        r = m;
        foreach (clr[i]) r[clr[i]] = 1'b0;
        r[63] = 1'b1;
        r[0]  = 1'b1;
        if (m[34:33] == 2'b10) r[34:33] = 2'b01;
        return r;
    endfunction

    function automatic logic [63:0] ref_save(input logic [63:0] m, input logic [4:0] c);
        logic [63:0] r;
        r = m;
        r[30:27] = 4'd0;
        r[21] = 1'b0;
        r[20] = c[0];
        r[18] = c[1];
        r[16] = c[3];
        r[19] = c[4];
        r[17] = (c == 5'd0);
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [63:0] m, input logic [63:0] pc,
                        input logic [4:0] c, input logic [OFF_W-1:0] off);
        @(negedge clk);
        trap_i = 1'b1; cur_msr_i = m; cur_pc_i = pc; cause_vec_i = c; vec_off_i = off;
        @(negedge clk);
        trap_i = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        #1;
        chk("R1 vld", {60'd0, new_msr_vld_o, save_pc_vld_o, save_msr_vld_o, fetch_pc_vld_o}, 64'd0);
        chk("R1 msr", new_msr_o, 64'd0);
        @(negedge clk); @(negedge clk);
        rst_ni = 1'b1;
        chk("R1 after", save_msr_o | fetch_pc_o | save_pc_o, 64'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [63:0] m, pc;
            logic [4:0] c;
            logic [OFF_W-1:0] off;
            {m, pc, c, off} = VEC[i];
            fire(m, pc, c, off);
            chk("R2/R3/R4 new msr", new_msr_o, ref_msr(m));
            chk("R5 save pc", save_pc_o, pc);
            chk("R6/R7/R8 save msr", save_msr_o, ref_save(m, c));
            chk("R9 fetch pc", fetch_pc_o, {48'd0, off, 4'd0});
            chk("R10 vld", {60'd0, new_msr_vld_o, save_pc_vld_o, save_msr_vld_o, fetch_pc_vld_o}, 64'hF);
        end

        // R10: idle cycle after a trap clears everything
        @(negedge clk);
        chk("R10 idle vld", {63'd0, new_msr_vld_o | save_pc_vld_o | save_msr_vld_o | fetch_pc_vld_o}, 64'd0);
        chk("R10 idle data", new_msr_o | save_pc_o | save_msr_o | fetch_pc_o, 64'd0);

        // R2 R3: all-ones MSR, hand value
        fire(64'hFFFF_FFFF_FFFF_FFFF, 64'h40, 5'b00100, 12'h000);
        chk("R2 clear set", new_msr_o, 64'hFFFF_FFFE_FD7F_1049);
        // R7: cause bit 2 alone gives no cause and no trap bit
        chk("R7 bit2 ignored", save_msr_o, 64'hFFFF_FFFF_87C2_FFFF & ~64'h0002_0000);
        // R8: zero cause sets only the trap bit
        fire(64'hFFFF_FFFF_FFFF_FFFF, 64'h40, 5'b00000, 12'h000);
        chk("R8 trap only", save_msr_o, 64'hFFFF_FFFF_87C2_FFFF);
        fire(64'd0, 64'h0, 5'b00000, 12'h000);
        chk("R8 zero msr", save_msr_o, 64'h0000_0000_0002_0000);
        chk("R3 zero msr", new_msr_o, 64'h8000_0000_0000_0001);
        // R4: every transaction state
        fire(64'h0000_0004_0000_0000, 64'h0, 5'b00001, 12'h000);
        chk("R4 ts10", new_msr_o, 64'h8000_0002_0000_0001);
        fire(64'h0000_0006_0000_0000, 64'h0, 5'b00001, 12'h000);
        chk("R4 ts11", new_msr_o, 64'h8000_0006_0000_0001);
        fire(64'h0000_0002_0000_0000, 64'h0, 5'b00001, 12'h000);
        chk("R4 ts01", new_msr_o, 64'h8000_0002_0000_0001);

        // R11: strobe held for back-to-back traps, each result one cycle later
        @(negedge clk);
        trap_i = 1'b1; cur_pc_i = 64'h100; vec_off_i = 12'h001;
        @(negedge clk);
        chk("R11 first", save_pc_o, 64'h100);
        cur_pc_i = 64'h200; vec_off_i = 12'h002;
        @(negedge clk);
        chk("R11 second", save_pc_o, 64'h200);
        chk("R9 second", fetch_pc_o, 64'h20);
        trap_i = 1'b0;
        @(negedge clk);
        chk("R10 drop", {63'd0, fetch_pc_vld_o}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule